// File: doc/BRIEF.md
# Single-Channel Memory Copy DMA Engine

This block copies a block of memory from one address range to another on behalf of a processor. Software programs a source address, a destination address and a count of transfer units into a small 32-bit register file. It then writes the channel control word with the enable bit set and the end flag clear. The engine moves the data one unit at a time over a memory request/response port. Each unit is a read from the source followed by a write of the same bytes to the destination. After each unit the engine steps the addresses and decrements the count.

A unit is 1, 2, 4 or 8 bytes, selected by a 2-bit size code. When the count reaches zero the engine sets the channel's end flag. It can raise an interrupt at that point. A global operation register gates all traffic. It holds a master enable and two error flags, one for a misaligned start and one for an external abort. A separate clear register abandons the channel at once, even in the middle of a transfer.

Top module: `xfer_dma_engine`

## Requirements
- R1: After reset, the source, destination, count and global registers read 0, `irq` is low, and the control word reads 0x0000_1320. That value means size code 2 (4 bytes), source increment on, destination increment on, auto-request on, and enable, end flag and interrupt enable off.
- R2: The count register at offset 0x08 keeps only its low 24 bits; bits 31:24 read back as zero.
- R3: The control word at 0x0C has these fields: bit 0 enable, bit 1 end flag, bit 2 interrupt enable, bits 5:4 size code, bit 8 source increment, bit 9 destination increment, bit 12 auto-request. The channel is busy exactly when enable is 1 and the end flag is 0.
- R4: Each unit issues one read request at the source address, then one write request at the destination address. The write carries the bytes returned by the read, and both requests carry the size code. A transfer moves count << size code bytes.
- R5: After a unit, the source address (0x00) grows by 2^size only if source increment is set. The destination address (0x04) follows the same rule with destination increment.
- R6: When the count reaches zero, the engine sets the end flag and leaves enable set. The live count then reads 0.
- R7: `irq` equals the end flag AND interrupt enable. It stays high until software clears the end flag or clears the channel.
- R8: While the channel is busy, writes to the source, destination, count and control registers are ignored.
- R9: A start whose source or destination is not a multiple of the unit size does not start the channel. It sets the address-error flag (bit 2 of the global register at 0x40), leaves enable at 0 and issues no memory request.
- R10: A unit starts only when the master enable (bit 0 at 0x40) is 1 and both the abort flag (bit 1) and the address-error flag are 0. A pulse on `abort_in` sets the abort flag. Writing the global register sets all three bits directly, and the transfer resumes once they allow it.
- R11: Any write to offset 0x10 clears enable, the end flag and the count, and abandons the unit in flight.
- R12: With auto-request 0, the channel stays busy and issues no memory request.
- R13: A start with a count of 0 sets the end flag without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 7 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 7 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| abort_in | input | 1 | External abort pulse; sets the abort flag |
| irq | output | 1 | Transfer-end interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_size | output | 2 | Unit size code of the request |
| mem_req_wdata | output | 64 | Write data, right-aligned |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned |

## Verification
The bench sweeps every size code, counts 1 to 3 and all four increment-mode pairs, with a memory that stalls requests. It compares the whole memory image, the final addresses and the live count against values it computes itself. A fixed-destination copy that kept writing through stale data, or an address that stepped by the byte count instead of the unit size, would show up in the memory image and the address readback. Separate cases cover these corner behaviours:
- a start with a misaligned address, which a wrong design would carry out;
- a zero count, which would otherwise wrap to a long transfer;
- register writes while busy, which would corrupt a running copy;
- traffic while the master enable is off or an error flag is set;
- the clear register issued while the channel is busy, which a wrong design would leave stuck busy or half-run.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  localparam int REG_W  = 32;
  localparam int OFS_W  = 7;
  localparam int DATA_W = 64;

  localparam logic [OFS_W-1:0] OFS_SRC  = 7'h00;
  localparam logic [OFS_W-1:0] OFS_DST  = 7'h04;
  localparam logic [OFS_W-1:0] OFS_CNT  = 7'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL = 7'h0C;
  localparam logic [OFS_W-1:0] OFS_CLR  = 7'h10;
  localparam logic [OFS_W-1:0] OFS_GLB  = 7'h40;

  localparam int C_EN   = 0;
  localparam int C_END  = 1;
  localparam int C_IE   = 2;
  localparam int C_SZ   = 4;
  localparam int C_SINC = 8;
  localparam int C_DINC = 9;
  localparam int C_AUTO = 12;

  localparam int G_ME   = 0;
  localparam int G_ABT  = 1;
  localparam int G_AERR = 2;

  localparam logic [1:0] SIZE_RST = 2'd2;

  typedef enum logic [1:0] {MV_IDLE, MV_RD_REQ, MV_RD_WAIT, MV_WR_REQ} mv_state_e;

  // bytes per unit for a size code
  function automatic logic [REG_W-1:0] unit_bytes(input logic [1:0] sz);
    return REG_W'(1) << sz;
  endfunction

  // address is a multiple of the unit size
  function automatic logic addr_aligned(input logic [REG_W-1:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b1;
      2'd1:    return a[0] == 1'b0;
      2'd2:    return a[1:0] == 2'b00;
      default: return a[2:0] == 3'b000;
    endcase
  endfunction

  // byte lanes valid for a unit of the given size
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DATA_W'(64'h0000_0000_0000_00FF);
      2'd1:    return DATA_W'(64'h0000_0000_0000_FFFF);
      2'd2:    return DATA_W'(64'h0000_0000_FFFF_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/xdma_regs.sv
module xdma_regs
  import xdma_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [OFS_W-1:0] rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             abort_in,
  input  logic             unit_done,
  input  logic             chan_done,
  output logic [REG_W-1:0] src_q,
  output logic [REG_W-1:0] dst_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [1:0]       size_q,
  output logic             s_inc_q,
  output logic             d_inc_q,
  output logic             auto_q,
  output logic             en_q,
  output logic             end_q,
  output logic             ie_q,
  output logic             me_q,
  output logic             abt_q,
  output logic             aerr_q,
  output logic             busy,
  output logic             run_ok,
  output logic             clr_pulse,
  output logic             ctrl_wr,
  output logic             start_bad
);
  localparam int PAD_W = REG_W - CNT_W;

  logic src_wr, dst_wr, cnt_wr, glb_wr, start_req;
  logic [REG_W-1:0] step;
  logic [1:0] new_size;

  assign src_wr    = wr_en && (wr_addr == OFS_SRC);
  assign dst_wr    = wr_en && (wr_addr == OFS_DST);
  assign cnt_wr    = wr_en && (wr_addr == OFS_CNT);
  assign ctrl_wr   = wr_en && (wr_addr == OFS_CTRL);
  assign glb_wr    = wr_en && (wr_addr == OFS_GLB);
  assign clr_pulse = wr_en && (wr_addr == OFS_CLR);

  assign busy      = en_q && !end_q;
  assign run_ok    = me_q && !abt_q && !aerr_q;
  assign step      = unit_bytes(size_q);
  assign new_size  = wr_data[C_SZ+1:C_SZ];
  assign start_req = ctrl_wr && !busy && wr_data[C_EN] && !wr_data[C_END];
  assign start_bad = start_req &&
                     !(addr_aligned(src_q, new_size) && addr_aligned(dst_q, new_size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      size_q  <= SIZE_RST;
      s_inc_q <= 1'b1;
      d_inc_q <= 1'b1;
      auto_q  <= 1'b1;
      en_q    <= 1'b0;
      end_q   <= 1'b0;
      ie_q    <= 1'b0;
      me_q    <= 1'b0;
      abt_q   <= 1'b0;
      aerr_q  <= 1'b0;
    end else begin
      if (src_wr && !busy)         src_q <= wr_data;
      else if (unit_done && s_inc_q) src_q <= src_q + step;

      if (dst_wr && !busy)         dst_q <= wr_data;
      else if (unit_done && d_inc_q) dst_q <= dst_q + step;

      if (clr_pulse)               cnt_q <= '0;
      else if (cnt_wr && !busy)    cnt_q <= wr_data[CNT_W-1:0];
      else if (unit_done)          cnt_q <= cnt_q - 1'b1;

      if (ctrl_wr && !busy) begin
        ie_q    <= wr_data[C_IE];
        size_q  <= new_size;
        s_inc_q <= wr_data[C_SINC];
        d_inc_q <= wr_data[C_DINC];
        auto_q  <= wr_data[C_AUTO];
      end

      if (clr_pulse) begin
        en_q  <= 1'b0;
        end_q <= 1'b0;
      end else if (ctrl_wr && !busy) begin
        en_q  <= wr_data[C_EN] && !start_bad;
        end_q <= wr_data[C_END];
      end else if (chan_done) begin
        end_q <= 1'b1;
      end

      if (glb_wr) begin
        me_q   <= wr_data[G_ME];
        abt_q  <= wr_data[G_ABT];
        aerr_q <= wr_data[G_AERR];
      end
      if (abort_in)  abt_q  <= 1'b1;
      if (start_bad) aerr_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_SRC:  rd_data = src_q;
      OFS_DST:  rd_data = dst_q;
      OFS_CNT:  rd_data = {{PAD_W{1'b0}}, cnt_q};
      OFS_CTRL: begin
        rd_data[C_EN]          = en_q;
        rd_data[C_END]         = end_q;
        rd_data[C_IE]          = ie_q;
        rd_data[C_SZ+1:C_SZ]   = size_q;
        rd_data[C_SINC]        = s_inc_q;
        rd_data[C_DINC]        = d_inc_q;
        rd_data[C_AUTO]        = auto_q;
      end
      OFS_GLB: begin
        rd_data[G_ME]   = me_q;
        rd_data[G_ABT]  = abt_q;
        rd_data[G_AERR] = aerr_q;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/xdma_mover.sv
module xdma_mover
  import xdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              run_ok,
  input  logic              auto_q,
  input  logic              cnt_zero,
  input  logic              clr_pulse,
  input  logic [REG_W-1:0]  src_q,
  input  logic [REG_W-1:0]  dst_q,
  input  logic [1:0]        size_q,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [REG_W-1:0]  mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              unit_done,
  output logic              chan_done
);
  mv_state_e state, state_nx;
  logic [DATA_W-1:0] hold_q;

  assign chan_done = (state == MV_IDLE) && busy && cnt_zero && !clr_pulse;
  assign unit_done = (state == MV_WR_REQ) && mem_req_ready && !clr_pulse;

  always_comb begin
    state_nx = state;
    case (state)
      MV_IDLE:    if (busy && !cnt_zero && run_ok && auto_q) state_nx = MV_RD_REQ;
      MV_RD_REQ:  if (mem_req_ready) state_nx = MV_RD_WAIT;
      MV_RD_WAIT: if (mem_rsp_valid) state_nx = MV_WR_REQ;
      MV_WR_REQ:  if (mem_req_ready) state_nx = MV_IDLE;
      default:    state_nx = MV_IDLE;
    endcase
    if (clr_pulse) state_nx = MV_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= MV_IDLE;
      hold_q <= '0;
    end else begin
      state <= state_nx;
      if (state == MV_RD_WAIT && mem_rsp_valid)
        hold_q <= mem_rsp_data & lane_mask(size_q);
    end
  end

  assign mem_req_valid = (state == MV_RD_REQ) || (state == MV_WR_REQ);
  assign mem_req_write = (state == MV_WR_REQ);
  assign mem_req_addr  = (state == MV_WR_REQ) ? dst_q : src_q;
  assign mem_req_size  = size_q;
  assign mem_req_wdata = hold_q;
endmodule

// File: rtl/xfer_dma_engine.sv
module xfer_dma_engine
  import xdma_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [6:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [6:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              abort_in,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [31:0]       mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data
);
  logic [REG_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       size_q;
  logic s_inc_q, d_inc_q, auto_q, en_q, end_q, ie_q, me_q, abt_q, aerr_q;
  logic busy, run_ok, clr_pulse, ctrl_wr, start_bad;
  logic unit_done, chan_done, cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign irq      = end_q && ie_q;

  xdma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata),
    .abort_in(abort_in), .unit_done(unit_done), .chan_done(chan_done),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .size_q(size_q),
    .s_inc_q(s_inc_q), .d_inc_q(d_inc_q), .auto_q(auto_q),
    .en_q(en_q), .end_q(end_q), .ie_q(ie_q),
    .me_q(me_q), .abt_q(abt_q), .aerr_q(aerr_q),
    .busy(busy), .run_ok(run_ok), .clr_pulse(clr_pulse),
    .ctrl_wr(ctrl_wr), .start_bad(start_bad)
  );

  xdma_mover u_mover (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .run_ok(run_ok), .auto_q(auto_q), .cnt_zero(cnt_zero),
    .clr_pulse(clr_pulse), .src_q(src_q), .dst_q(dst_q), .size_q(size_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .unit_done(unit_done), .chan_done(chan_done)
  );
endmodule

// File: rtl/xdma_checker.sv
module xdma_checker
  import xdma_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             busy,
  input logic             run_ok,
  input logic             auto_q,
  input logic             end_q,
  input logic             clr_pulse,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [REG_W-1:0] src_q,
  input logic [REG_W-1:0] dst_q,
  input logic [1:0]       size_q,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [REG_W-1:0] mem_req_addr
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !clr_pulse) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write && !clr_pulse) |=>
      (cnt_q == $past(cnt_q) - 1'b1));

  assert_end_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(end_q) && !$past(ctrl_wr)) |-> (cnt_q == '0));

  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  assert_locked_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && !clr_pulse) |=> ($stable(size_q) && $stable(auto_q)));

  assert_busy_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr_aligned(src_q, size_q) && addr_aligned(dst_q, size_q)));

  assert_gated_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid && !mem_req_write) |-> $past(run_ok && auto_q && busy));
endmodule

bind xfer_dma_engine xdma_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .busy(busy), .run_ok(run_ok),
  .auto_q(auto_q), .end_q(end_q), .clr_pulse(clr_pulse), .ctrl_wr(ctrl_wr),
  .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q), .size_q(size_q),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr)
);

// File: tb/sim_xfer_dma_engine.sv
`timescale 1ns/1ps
module sim_xfer_dma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [6:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [6:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        abort_in = 1'b0;
  logic        irq;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  xfer_dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .abort_in(abort_in), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  localparam logic [6:0] A_SRC = 7'h00, A_DST = 7'h04, A_CNT = 7'h08,
                         A_CTRL = 7'h0C, A_CLR = 7'h10, A_GLB = 7'h40;

  // memory model: 256 bytes, stalls every third cycle
  logic [7:0]  mem [0:255];
  logic [7:0]  ref_mem [0:255];
  logic        init_go = 1'b0;
  logic [7:0]  seed = '0;
  int          req_cnt = 0;
  int          cyc = 0;
  logic        rsp_v = 1'b0;
  logic [63:0] rsp_d = '0;

  assign mem_req_ready = (cyc % 3) != 2;
  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_data  = rsp_d;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rsp_v <= 1'b0;
    if (init_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 13 + int'(seed));
    end else if (mem_req_valid && mem_req_ready) begin
      req_cnt <= req_cnt + 1;
      if (mem_req_write) begin
        for (int b = 0; b < (1 << mem_req_size); b++)
          mem[8'(mem_req_addr + 32'(b))] <= mem_req_wdata[b*8 +: 8];
      end else begin
        rsp_v <= 1'b1;
        for (int b = 0; b < 8; b++)
          rsp_d[b*8 +: 8] <= mem[8'(mem_req_addr + 32'(b))];
      end
    end
  end

  int tests = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic load_mem(input logic [7:0] s);
    @(negedge clk);
    seed = s; init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 13 + int'(s));
  endtask

  function automatic logic [31:0] ctrl_word(input int sz, input bit si, input bit di,
                                           input bit au, input bit ie, input bit en);
    return (32'(au) << 12) | (32'(di) << 9) | (32'(si) << 8) |
           (32'(sz) << 4) | (32'(ie) << 2) | 32'(en);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_SRC, v);  chk("R1 src reset", v, 32'h0);
    rd(A_DST, v);  chk("R1 dst reset", v, 32'h0);
    rd(A_CNT, v);  chk("R1 cnt reset", v, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0000_1320);
    rd(A_GLB, v);  chk("R1 glb reset", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 count width
    wr(A_CNT, 32'hFFFF_FFFF);
    rd(A_CNT, v); chk("R2 cnt width", v, 32'h00FF_FFFF);

    wr(A_GLB, 32'h1);

    // sweep: size, count, increment modes
    for (int sz = 0; sz < 4; sz++)
      for (int n = 1; n <= 3; n++)
        for (int m = 0; m < 4; m++) begin
          bit si = m[0];
          bit di = m[1];
          int s, d, mism;
          load_mem(8'(sz * 16 + n * 4 + m));
          s = 32'h10; d = 32'h80;
          for (int u = 0; u < n; u++) begin
            for (int b = 0; b < (1 << sz); b++) ref_mem[d + b] = ref_mem[s + b];
            if (si) s += (1 << sz);
            if (di) d += (1 << sz);
          end
          wr(A_SRC, 32'h10); wr(A_DST, 32'h80); wr(A_CNT, 32'(n));
          wr(A_CTRL, ctrl_word(sz, si, di, 1'b1, 1'b1, 1'b1));
          rd(A_CTRL, v); chk("R3 busy after start", v & 32'h3, 32'h1);
          wait_irq();
          chk("R7 irq at end", 32'(irq), 32'h1);
          mism = 0;
          for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
          chk("R4 memory image", 32'(mism), 32'h0);
          rd(A_CNT, v);  chk("R6 count zero", v, 32'h0);
          rd(A_CTRL, v); chk("R6 end flag with enable", v & 32'h3, 32'h3);
          rd(A_SRC, v);  chk("R5 src final", v, 32'h10 + (si ? 32'(n << sz) : 32'h0));
          rd(A_DST, v);  chk("R5 dst final", v, 32'h80 + (di ? 32'(n << sz) : 32'h0));
          wr(A_CTRL, 32'h0000_1320);
          chk("R7 irq cleared", 32'(irq), 32'h0);
        end

    // R10 master enable off holds traffic, R8 writes while busy ignored
    wr(A_GLB, 32'h0);
    load_mem(8'h5A);
    for (int i = 0; i < 8; i++) ref_mem[32'h80 + i] = ref_mem[32'h10 + i];
    wr(A_SRC, 32'h10); wr(A_DST, 32'h80); wr(A_CNT, 32'd2);
    wr(A_CTRL, ctrl_word(2, 1, 1, 1, 1, 1));
    base = req_cnt;
    repeat (20) @(negedge clk);
    chk("R10 no traffic without enable", 32'(req_cnt - base), 32'h0);
    wr(A_SRC, 32'h40); wr(A_CNT, 32'd7);
    wr(A_CTRL, ctrl_word(0, 0, 0, 0, 0, 1));
    rd(A_SRC, v);  chk("R8 src locked", v, 32'h10);
    rd(A_CNT, v);  chk("R8 cnt locked", v, 32'h2);
    rd(A_CTRL, v); chk("R8 ctrl locked", v, 32'h0000_1325);
    wr(A_GLB, 32'h1);
    wait_irq();
    chk("R10 resumes", 32'(irq), 32'h1);
    chk("R4 request count", 32'(req_cnt - base), 32'h4);
    begin
      int mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
      chk("R4 resumed image", 32'(mism), 32'h0);
    end
    wr(A_CTRL, 32'h0000_1320);

    // R10 abort flag
    @(negedge clk); abort_in = 1'b1;
    @(negedge clk); abort_in = 1'b0;
    rd(A_GLB, v); chk("R10 abort flag", v, 32'h3);
    wr(A_SRC, 32'h10); wr(A_DST, 32'h80); wr(A_CNT, 32'd1);
    wr(A_CTRL, ctrl_word(2, 1, 1, 1, 1, 1));
    base = req_cnt;
    repeat (20) @(negedge clk);
    chk("R10 abort holds traffic", 32'(req_cnt - base), 32'h0);
    wr(A_GLB, 32'h1);
    wait_irq();
    chk("R10 after abort cleared", 32'(irq), 32'h1);
    wr(A_CTRL, 32'h0000_1320);

    // R9 misaligned start
    wr(A_SRC, 32'h11); wr(A_DST, 32'h80); wr(A_CNT, 32'd1);
    base = req_cnt;
    wr(A_CTRL, ctrl_word(2, 1, 1, 1, 1, 1));
    rd(A_GLB, v);  chk("R9 address error flag", v, 32'h5);
    rd(A_CTRL, v); chk("R9 not enabled", v & 32'h3, 32'h0);
    repeat (10) @(negedge clk);
    chk("R9 no traffic", 32'(req_cnt - base), 32'h0);
    wr(A_GLB, 32'h1);
    wr(A_SRC, 32'h10);

    // R11 clear while busy
    wr(A_GLB, 32'h0);
    wr(A_CNT, 32'd3);
    wr(A_CTRL, ctrl_word(2, 1, 1, 1, 1, 1));
    wr(A_CLR, 32'h0);
    rd(A_CTRL, v); chk("R11 enable and end cleared", v & 32'h3, 32'h0);
    rd(A_CNT, v);  chk("R11 count cleared", v, 32'h0);
    base = req_cnt;
    wr(A_GLB, 32'h1);
    repeat (10) @(negedge clk);
    chk("R11 no traffic after clear", 32'(req_cnt - base), 32'h0);
    chk("R11 no irq", 32'(irq), 32'h0);

    // R12 auto-request off
    wr(A_CNT, 32'd2);
    wr(A_CTRL, ctrl_word(2, 1, 1, 0, 1, 1));
    base = req_cnt;
    repeat (20) @(negedge clk);
    chk("R12 no traffic without auto", 32'(req_cnt - base), 32'h0);
    rd(A_CTRL, v); chk("R12 still busy", v & 32'h3, 32'h1);
    wr(A_CLR, 32'h0);

    // R13 zero count
    wr(A_CNT, 32'd0);
    base = req_cnt;
    wr(A_CTRL, ctrl_word(2, 1, 1, 1, 1, 1));
    wait_irq();
    chk("R13 end with zero count", 32'(irq), 32'h1);
    chk("R13 no traffic", 32'(req_cnt - base), 32'h0);
    wr(A_CTRL, 32'h0000_1320);

    report();
  end
endmodule